// File: doc/BRIEF.md
# Halfband Decimate-by-Two Filter

This block takes a stream of signed samples, runs them through a linear-phase halfband lowpass FIR and keeps one result for every two samples it accepts, so the output rate is half the input rate. In a wideband oversampled converter it sits after the integrator-comb stages, which deliver samples at twice the final rate; its output is the stream at the final rate. The transition band is centred at a quarter of the input sample rate.

The samples are split by arrival order into two polyphase branches held in separate shift registers. One branch feeds the nonzero mirrored taps. Each mirrored pair is added before its coefficient is applied. The other branch only needs to supply the centre sample, whose weight of one half is a single shift. Every coefficient product is a fixed shift-and-subtract network built from a signed-digit pattern given as a parameter, so the block contains no general multiplier. The full-precision sum is rounded to the nearest integer and clipped to the output width.

Top module: `hb_decim2`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` goes to 0, `out_data` to 0, both branch delay lines to zero and the phase to "odd". After reset, the outputs depend only on samples accepted after it.
- R2: Exactly one output is produced for every two accepted samples. The pair-completing sample is taken at edge E. `out_valid` is high for exactly the one cycle that follows edge E+1, and it is never high in two consecutive cycles.
- R3: The first sample accepted after reset is an odd-phase sample. Phases then strictly alternate between accepted samples. Cycles with `in_valid` low do not advance the phase. An output is formed on each even-phase sample, called x[n].
- R4: With T = 4*NHALF+3 taps and centre index C = 2*NHALF+1, the output is the sum over k of h[k]*x[n-k]. h[C] = 1/2, and h[k] = 0 where |k-C| is even and nonzero.
- R5: Taps are symmetric, h[k] = h[T-1-k]. Each is a 24-bit fraction given in signed digits with no two adjacent nonzero digits. With the default NHALF = 2, h[0] = 3/256, h[2] = -18/256 and h[4] = 79/256.
- R6: The sum is rounded to the nearest integer, with exact halves going toward positive infinity. For example, +1.5 gives 2 and -1.5 gives -1.
- R7: A rounded value above 2^(OW-1)-1 gives 2^(OW-1)-1. A value below -2^(OW-1) gives -2^(OW-1).
- R8: `out_data` changes only in a cycle where `out_valid` is high, and holds its value otherwise.
- R9: `in_data` has no effect in cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_data | output | OW | Signed, rounded and saturated output |

## Verification
The assertions assume that `in_valid` carries at most one sample per cycle. They also assume that nothing upstream repeats or drops samples, because the two-cycle gap between outputs depends on this. The bench applies at most one sample per cycle and inserts random idle cycles that carry random `in_data`. Directed sequences reach the rounding and clipping corners without relying on the random stimulus, because random data rarely lines up with the coefficient signs.

// File: rtl/hb_pkg.sv
// Shared constants for the halfband decimator.
// Assumes coefficients are unsigned-magnitude signed-digit masks of HB_CW bits.
package hb_pkg;
    // Fractional bits of every coefficient
    parameter int HB_CW = 24;

    // Accumulator width: data, coefficient, tap growth and pair-sum headroom
    function automatic int hb_acc_width(input int dw, input int ntaps);
        return dw + HB_CW + $clog2(ntaps) + 2;
    endfunction
endpackage

// File: rtl/hb_phase_ctrl.sv
// Polyphase steering: alternates accepted samples between the odd and even
// branches and raises calc one cycle after each even (pair-completing) sample.
// Assumes at most one sample per cycle.
module hb_phase_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic push_odd,
    output logic push_even,
    output logic calc
);
    logic phase_q;

    assign push_odd  = in_valid && !phase_q;
    assign push_even = in_valid &&  phase_q;

    // Toggle the phase on every accepted sample; delay the even strobe by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            calc    <= 1'b0;
        end else begin
            if (in_valid) phase_q <= !phase_q;
            calc <= push_even;
        end
    end

    // R3: two even samples never arrive without an odd one between them
    p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_even |=> !push_even);
endmodule

// File: rtl/hb_delay_line.sv
// Enabled shift register for one polyphase branch. FULL=1 exposes every
// stage (newest at index 0); FULL=0 exposes only the oldest stage.
// Assumes DEPTH >= 2.
module hb_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 4,
    parameter bit FULL  = 1'b1,
    parameter int OUTN  = FULL ? DEPTH : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [W-1:0]              din,
    output logic [OUTN-1:0][W-1:0]    taps
);
    logic [DEPTH-1:0][W-1:0] stage;

    // Shift a new sample in at index 0 when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (en) begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    generate
        if (FULL) begin : g_all
            assign taps = stage;
        end else begin : g_tail
            assign taps[0] = stage[DEPTH-1];
        end
    endgenerate

    // R4: sample order along the line is preserved by each shift
    p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> stage[DEPTH-1] == $past(stage[DEPTH-2]));
endmodule

// File: rtl/hb_csd_mac.sv
// Combinational halfband sum: pre-adds mirrored even-branch taps, applies
// each coefficient as a fixed signed-digit shift-add network, and adds the
// centre sample at weight one half. Result is in units of 2^-HB_CW.
module hb_csd_mac
    import hb_pkg::*;
#(
    parameter int NHALF = 2,
    parameter int DW    = 12,
    parameter int AW    = 42,
    parameter logic [NHALF:0][HB_CW-1:0] CSD_POS = '0,
    parameter logic [NHALF:0][HB_CW-1:0] CSD_NEG = '0
) (
    input  logic [2*NHALF+1:0][DW-1:0] even_taps,
    input  logic [DW-1:0]              centre,
    output logic signed [AW-1:0]       acc
);
    localparam int NE = 2 * NHALF + 2;

    logic signed [AW-1:0] pair [NHALF+1];

    // Pre-add each mirrored pair of even-branch samples
    always_comb begin
        for (int j = 0; j <= NHALF; j++) begin
            pair[j] = $signed({{(AW-DW){even_taps[j][DW-1]}}, even_taps[j]})
                    + $signed({{(AW-DW){even_taps[NE-1-j][DW-1]}}, even_taps[NE-1-j]});
        end
    end

    // Shift-add network over the signed digits, plus the centre half-weight
    always_comb begin
        acc = $signed({{(AW-DW){centre[DW-1]}}, centre}) <<< (HB_CW - 1);
        for (int j = 0; j <= NHALF; j++) begin
            for (int b = 0; b < HB_CW; b++) begin
                if (CSD_POS[j][b]) acc = acc + (pair[j] <<< b);
                if (CSD_NEG[j][b]) acc = acc - (pair[j] <<< b);
            end
        end
    end
endmodule

// File: rtl/hb_round_sat.sv
// Output stage: rounds the fixed-point sum to nearest (halves upward),
// clips to OW bits and registers it with a one-cycle valid strobe.
module hb_round_sat
    import hb_pkg::*;
#(
    parameter int AW = 42,
    parameter int OW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [AW-1:0] acc,
    output logic                 out_valid,
    output logic [OW-1:0]        out_data
);
    localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (HB_CW - 1));
    localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (OW - 1)) - 1);
    localparam logic signed [AW-1:0] MINV = AW'(-(64'sd1 <<< (OW - 1)));

    logic signed [AW-1:0] rnd;
    logic signed [AW-1:0] clipped;

    // Round half up, then clip to the output range
    always_comb begin
        rnd = (acc + HALF) >>> HB_CW;
        if (rnd > MAXV)      clipped = MAXV;
        else if (rnd < MINV) clipped = MINV;
        else                 clipped = rnd;
    end

    // Register the result only when a new sum is ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= load;
            if (load) out_data <= clipped[OW-1:0];
        end
    end

    // R8: the output word moves only together with the strobe
    p_data_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);
endmodule

// File: rtl/hb_decim2.sv
// Halfband decimate-by-two FIR top. Odd-phase samples feed a short line
// whose oldest entry is the centre tap; even-phase samples feed the line of
// mirrored nonzero taps. One rounded, clipped output per sample pair.
// Assumes at most one input sample per clock.
module hb_decim2
    import hb_pkg::*;
#(
    parameter int NHALF = 2,
    parameter int DW    = 12,
    parameter int OW    = 12,
    parameter logic [NHALF:0][HB_CW-1:0] CSD_POS =
        {24'h500000, 24'h000000, 24'h040000},
    parameter logic [NHALF:0][HB_CW-1:0] CSD_NEG =
        {24'h010000, 24'h120000, 24'h010000}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);
    localparam int NTAPS = 4 * NHALF + 3;
    localparam int AW    = hb_acc_width(DW, NTAPS);
    localparam int NEVEN = 2 * NHALF + 2;
    localparam int NODD  = NHALF + 1;

    logic                       push_odd, push_even, calc;
    logic [NEVEN-1:0][DW-1:0]   even_taps;
    logic [0:0][DW-1:0]         odd_tail;
    logic signed [AW-1:0]       acc;

    hb_phase_ctrl u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .push_odd  (push_odd),
        .push_even (push_even),
        .calc      (calc)
    );

    hb_delay_line #(.W(DW), .DEPTH(NODD), .FULL(1'b0)) u_odd_line (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (push_odd),
        .din   (in_data),
        .taps  (odd_tail)
    );

    hb_delay_line #(.W(DW), .DEPTH(NEVEN), .FULL(1'b1)) u_even_line (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (push_even),
        .din   (in_data),
        .taps  (even_taps)
    );

    hb_csd_mac #(
        .NHALF(NHALF), .DW(DW), .AW(AW),
        .CSD_POS(CSD_POS), .CSD_NEG(CSD_NEG)
    ) u_mac (
        .even_taps (even_taps),
        .centre    (odd_tail[0]),
        .acc       (acc)
    );

    hb_round_sat #(.AW(AW), .OW(OW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (calc),
        .acc       (acc),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R2: a strobe never lasts more than one cycle
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2: every strobe follows an accepted sample two edges earlier
    p_strobe_after_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/hb_decim2_tb_top.sv
// Self-checking bench: random samples with idle gaps, a reference model
// built from the stated coefficients, and directed rounding/clipping cases.
module hb_decim2_tb_top;
    localparam int DW = 12;
    localparam int OW = 12;
    localparam int NT = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;

    always #4 clk = !clk;

    hb_decim2 dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int pcount = 0;
    bit done = 1'b0;

    int hist [NT];
    bit mphase = 1'b0;
    int exp_q [$];
    int due_q [$];
    int got_q [$];
    int last_out = 0;

    always @(posedge clk) pcount <= pcount + 1;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Tap weights in units of 2^-24, from R4/R5
    function automatic longint coef(input int k);
        int d;
        d = (k > 5) ? 10 - k : k;
        case (d)
            0: return 3 * 65536;
            2: return -18 * 65536;
            4: return 79 * 65536;
            5: return 64'sd1 <<< 23;
            default: return 0;
        endcase
    endfunction

    function automatic int model_out();
        longint acc = 0;
        longint r;
        for (int k = 0; k < NT; k++) acc += coef(k) * hist[k];
        r = (acc + (64'sd1 <<< 23)) >>> 24;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return int'(r);
    endfunction

    task automatic model_clear();
        for (int k = 0; k < NT; k++) hist[k] = 0;
        mphase = 1'b0;
    endtask

    // Drive one accepted sample at a falling edge
    task automatic put(input int v);
        in_valid = 1'b1;
        in_data = v[DW-1:0];
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
        if (mphase) begin
            exp_q.push_back(model_out());
            due_q.push_back(pcount + 2);
        end
        mphase = !mphase;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Idle cycle carrying junk data (R9)
    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            in_valid = 1'b0;
            in_data = DW'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        idle(4);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_data in reset", int'(out_data), 0);
        model_clear();
        last_out = 0;
        rst_n = 1'b1;
    endtask

    // Monitor: timing, value, hold and spurious-strobe checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 strobe without pair", 1, 0);
                end else begin
                    check("R2 strobe cycle", pcount, due_q.pop_front());
                    check("R4/R6/R7 output value", $signed(out_data), exp_q.pop_front());
                end
                last_out = $signed(out_data);
                got_q.push_back($signed(out_data));
            end else begin
                check("R8 hold", $signed(out_data), last_out);
                if (due_q.size() != 0 && due_q[0] <= pcount)
                    check("R2 missing strobe", 0, 1);
            end
        end
    end

    task automatic run_seq(input int v[], input int idx, input int exp_v, input string req);
        do_reset();
        got_q.delete();
        foreach (v[i]) put(v[i]);
        idle(4);
        check(req, (got_q.size() > idx) ? got_q[idx] : 99999, exp_v);
    endtask

    initial begin
        int seq[];
        void'($urandom(1234));
        model_clear();
        @(negedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_data in reset", int'(out_data), 0);
        rst_n = 1'b1;

        // R3/R4: impulse on odd phase hits only the centre tap
        do_reset();
        got_q.delete();
        put(1024);
        for (int i = 0; i < 13; i++) put(0);
        idle(4);
        check("R3 odd impulse out0", got_q[0], 0);
        check("R4 odd impulse centre", got_q[2], 512);
        check("R4 odd impulse out4", got_q[4], 0);

        // R5: impulse on even phase reveals mirrored taps
        do_reset();
        got_q.delete();
        put(0);
        put(1024);
        for (int i = 0; i < 12; i++) put(0);
        idle(4);
        check("R5 tap0", got_q[0], 12);
        check("R5 tap2", got_q[1], -72);
        check("R5 tap4", got_q[2], 316);
        check("R5 tap6 mirror", got_q[3], 316);
        check("R5 tap8 mirror", got_q[4], -72);
        check("R5 tap10 mirror", got_q[5], 12);

        // R6: exact halves at the centre tap
        seq = '{3, 0, 0, 0, 0, 0};
        run_seq(seq, 2, 2, "R6 +1.5 rounds to 2");
        seq = '{-3, 0, 0, 0, 0, 0};
        run_seq(seq, 2, -1, "R6 -1.5 rounds to -1");
        seq = '{1, 0, 0, 0, 0, 0};
        run_seq(seq, 2, 1, "R6 +0.5 rounds to 1");

        // R7: signs matched to the taps drive past both rails
        seq = '{2047, 2047, 2047, -2048, 2047, 2047, 2047, 2047, 2047, -2048, 2047, 2047};
        run_seq(seq, 5, 2047, "R7 clip high");
        seq = '{-2048, -2048, -2048, 2047, -2048, -2048, -2048, -2048, -2048, 2047, -2048, -2048};
        run_seq(seq, 5, -2048, "R7 clip low");

        // R3/R9: random samples with junk-carrying idle gaps
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 3);
            if (r == 0) idle($urandom_range(1, 3));
            if (i % 500 < 100) put(($urandom_range(0, 1) == 1) ? 2047 : -2048);
            else put($urandom_range(0, 4095) - 2048);
        end
        idle(6);

        // R1: mid-stream reset clears history
        do_reset();
        got_q.delete();
        put(0);
        put(100);
        idle(4);
        check("R1 cleared history", got_q[0], 1);
        check("R2 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule